// File: doc/BRIEF.md
# Power-Stage Configuration Detection Sequencer

This block decides, once per power-up, whether a two-rail buck regulator runs as two independent output channels or as a single rail driven by two phases. When both supply monitors report ready and at least one channel enable is requested, it waits a short settling delay. It then opens a timed detection window in which the shared mode pin is held only by a weak internal pulldown. At the close of the window the digitized pin comparator is sampled once. A pin strapped high selects dual-channel operation and the pin is released. A pin left low selects two-phase operation and the pin is clamped by a strong pulldown.

In two-phase operation the mode pin drives the gate of the external rail-sharing switch. Once both rails report power-good, the block turns on a small soft-on current source that charges the gate slowly. When a second comparator shows the pin near the supply, the current source is replaced by a strong pull-up and sequencing is complete. Losing either power-good returns the pin to the strong pulldown. The chosen mode stays latched until a supply monitor drops.

All analog parts (comparators, drivers, current source) are outside the block and exchange digital levels with it. Time is measured in ticks of the block clock, and the delay and window lengths are parameters.

Top module: `pstage_cfg_seq`

## Requirements
- R1: While either supply-ready flag is low, or no enable is asserted, all four pin drive enables, `mode_two_phase` and `seq_done` stay 0.
- R2: The weak pulldown first turns on exactly DLY_TICKS clock cycles after the first rising clock edge at which both supplies are ready and an enable is high.
- R3: The weak pulldown stays on for exactly WIN_TICKS consecutive cycles and is never on at any other time.
- R4: If `pin_hi_det` is 1 in the last window cycle, the block latches dual-channel mode (`mode_two_phase`=0), turns every pin drive enable off and raises `seq_done` on the next cycle.
- R5: If `pin_hi_det` is 0 in the last window cycle, the block latches two-phase mode (`mode_two_phase`=1) and turns on `pd_strong_en` on the next cycle, with `seq_done`=0.
- R6: In two-phase mode `soft_on_en` turns on only on the cycle after both `pg_a` and `pg_b` are sampled high, and stays on while `pin_top_det` is 0.
- R7: While `soft_on_en` is on, `pin_top_det`=1 with both power-good flags high makes the next cycle show `pu_strong_en`=1 and `seq_done`=1.
- R8: In two-phase mode, either power-good flag sampled low during the soft-on or pulled-up phase returns the next cycle to `pd_strong_en`=1 with `seq_done`=0.
- R9: Once a mode is latched, toggling the enables or `pin_hi_det` neither changes `mode_two_phase` nor turns the weak pulldown on again.
- R10: A supply-ready flag sampled low returns the block to its idle state on the next cycle, clearing the mode and all drives. Detection then runs again once supplies and an enable are present.
- R11: At most one of `pd_weak_en`, `pd_strong_en`, `soft_on_en` and `pu_strong_en` is on in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_ok | input | 1 | Input supply monitor reports ready |
| vcc_ok | input | 1 | Control supply monitor reports ready |
| en_a | input | 1 | Enable request, channel A |
| en_b | input | 1 | Enable request, channel B |
| pin_hi_det | input | 1 | Mode pin above supply minus 0.5 V |
| pin_top_det | input | 1 | Mode pin above supply minus 0.2 V |
| pg_a | input | 1 | Power-good, channel A |
| pg_b | input | 1 | Power-good, channel B |
| mode_two_phase | output | 1 | Latched mode: 1 two-phase, 0 dual-channel |
| pd_weak_en | output | 1 | Weak pulldown on the mode pin |
| pd_strong_en | output | 1 | Strong pulldown on the mode pin |
| soft_on_en | output | 1 | Soft-on current source into the mode pin |
| pu_strong_en | output | 1 | Strong pull-up on the mode pin |
| seq_done | output | 1 | Configuration sequencing complete |

## Verification
Detection is tried with the pin comparator toggling at random through the window and settling high or low only in its final cycle. This separates a decision sampled at the window end from one taken early or late, and the measured delay and window lengths separate off-by-one timers. Power-good patterns with only one flag high, both high, and a drop during soft-on and after pull-up tell correct gating of the sharing-switch ramp from premature or sticky ramping. Enable and pin toggles after latching, plus supply drops at random points, show whether the mode is truly held and truly reset.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_DETECT,
        ST_DUAL,
        ST_TP_WAIT,
        ST_TP_SOFT,
        ST_TP_ON
    } seq_state_e;

    typedef struct packed {
        logic pd_weak;
        logic pd_strong;
        logic soft_on;
        logic pu_strong;
        logic done;
    } pin_drive_t;

    typedef struct packed {
        seq_state_e state;
        logic       two_phase;
    } seq_regs_t;

endpackage

// File: rtl/pscfg_tick_timer.sv
module pscfg_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)                 cnt_d = '0;
        else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/pscfg_drive_dec.sv
module pscfg_drive_dec
    import pscfg_pkg::*;
(
    input  seq_state_e state,
    output pin_drive_t drv
);
    always_comb begin
        drv = '0;
        unique case (state)
            ST_DETECT:  drv.pd_weak   = 1'b1;
            ST_DUAL:    drv.done      = 1'b1;
            ST_TP_WAIT: drv.pd_strong = 1'b1;
            ST_TP_SOFT: drv.soft_on   = 1'b1;
            ST_TP_ON: begin
                drv.pu_strong = 1'b1;
                drv.done      = 1'b1;
            end
            default: drv = '0;
        endcase
    end
endmodule

// File: rtl/pstage_cfg_seq.sv
module pstage_cfg_seq
    import pscfg_pkg::*;
#(
    parameter int DLY_TICKS = 438,
    parameter int WIN_TICKS = 6625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin_ok,
    input  logic vcc_ok,
    input  logic en_a,
    input  logic en_b,
    input  logic pin_hi_det,
    input  logic pin_top_det,
    input  logic pg_a,
    input  logic pg_b,
    output logic mode_two_phase,
    output logic pd_weak_en,
    output logic pd_strong_en,
    output logic soft_on_en,
    output logic pu_strong_en,
    output logic seq_done
);
    localparam int SPAN = (DLY_TICKS > WIN_TICKS) ? DLY_TICKS : WIN_TICKS;
    localparam int CW   = $clog2(SPAN + 1);
    localparam logic [CW-1:0] DLY_LAST = CW'(DLY_TICKS - 1);
    localparam logic [CW-1:0] WIN_LAST = CW'(WIN_TICKS - 1);

    seq_regs_t     r_d, r_q;
    logic [CW-1:0] tick;
    logic          tick_clr;
    logic          sup_ok, any_en, pg_both;
    pin_drive_t    drv;

    assign sup_ok  = vin_ok & vcc_ok;
    assign any_en  = en_a | en_b;
    assign pg_both = pg_a & pg_b;

    always_comb begin
        r_d = r_q;
        if (!sup_ok) begin
            r_d.state     = ST_IDLE;
            r_d.two_phase = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_IDLE:    if (any_en) r_d.state = ST_DELAY;
                ST_DELAY:   if (tick == DLY_LAST) r_d.state = ST_DETECT;
                ST_DETECT: begin
                    if (tick == WIN_LAST) begin
                        if (pin_hi_det) begin
                            r_d.state     = ST_DUAL;
                            r_d.two_phase = 1'b0;
                        end else begin
                            r_d.state     = ST_TP_WAIT;
                            r_d.two_phase = 1'b1;
                        end
                    end
                end
                ST_DUAL:    r_d.state = ST_DUAL;
                ST_TP_WAIT: if (pg_both) r_d.state = ST_TP_SOFT;
                ST_TP_SOFT: begin
                    if (!pg_both)         r_d.state = ST_TP_WAIT;
                    else if (pin_top_det) r_d.state = ST_TP_ON;
                end
                ST_TP_ON:   if (!pg_both) r_d.state = ST_TP_WAIT;
                default: begin
                    r_d.state     = ST_IDLE;
                    r_d.two_phase = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, two_phase: 1'b0};
        else        r_q <= r_d;
    end

    assign tick_clr = (r_d.state != r_q.state);

    pscfg_tick_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .cnt   (tick)
    );

    pscfg_drive_dec u_dec (
        .state (r_q.state),
        .drv   (drv)
    );

    assign mode_two_phase = r_q.two_phase;
    assign pd_weak_en     = drv.pd_weak;
    assign pd_strong_en   = drv.pd_strong;
    assign soft_on_en     = drv.soft_on;
    assign pu_strong_en   = drv.pu_strong;
    assign seq_done       = drv.done;
endmodule

// File: rtl/pscfg_seq_chk.sv
module pscfg_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic vin_ok,
    input logic vcc_ok,
    input logic pg_a,
    input logic pg_b,
    input logic mode_two_phase,
    input logic pd_weak_en,
    input logic pd_strong_en,
    input logic soft_on_en,
    input logic pu_strong_en,
    input logic seq_done
);
    logic sup;
    assign sup = vin_ok & vcc_ok;

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pd_weak_en, pd_strong_en, soft_on_en, pu_strong_en})); // R11

    AST_SUPPLY_LOSS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sup |=> !mode_two_phase && !pd_weak_en && !pd_strong_en && !soft_on_en
                 && !pu_strong_en && !seq_done); // R10

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && sup) |=> $stable(mode_two_phase)); // R9

    AST_DUAL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !mode_two_phase) |-> !pd_weak_en && !pd_strong_en
                                         && !soft_on_en && !pu_strong_en); // R4

    AST_SOFT_NEEDS_PG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_on_en) |-> $past(pg_a && pg_b)); // R6

    AST_PG_DROP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        ((pu_strong_en || soft_on_en) && !(pg_a && pg_b) && sup) |=> pd_strong_en); // R8

    AST_WEAK_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pd_weak_en |-> !seq_done && !mode_two_phase); // R3
endmodule

bind pstage_cfg_seq pscfg_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .vin_ok         (vin_ok),
    .vcc_ok         (vcc_ok),
    .pg_a           (pg_a),
    .pg_b           (pg_b),
    .mode_two_phase (mode_two_phase),
    .pd_weak_en     (pd_weak_en),
    .pd_strong_en   (pd_strong_en),
    .soft_on_en     (soft_on_en),
    .pu_strong_en   (pu_strong_en),
    .seq_done       (seq_done)
);

// File: tb/pstage_cfg_seq_tb.sv
module pstage_cfg_seq_tb;
    localparam int DLY = 6;
    localparam int WIN = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vin_ok = 0, vcc_ok = 0, en_a = 0, en_b = 0;
    logic pin_hi_det = 0, pin_top_det = 0, pg_a = 0, pg_b = 0;
    logic mode_two_phase, pd_weak_en, pd_strong_en, soft_on_en, pu_strong_en, seq_done;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int unsigned seed_v;

    always #4 clk = ~clk;

    pstage_cfg_seq #(.DLY_TICKS(DLY), .WIN_TICKS(WIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok), .vcc_ok(vcc_ok),
        .en_a(en_a), .en_b(en_b), .pin_hi_det(pin_hi_det), .pin_top_det(pin_top_det),
        .pg_a(pg_a), .pg_b(pg_b), .mode_two_phase(mode_two_phase),
        .pd_weak_en(pd_weak_en), .pd_strong_en(pd_strong_en), .soft_on_en(soft_on_en),
        .pu_strong_en(pu_strong_en), .seq_done(seq_done)
    );

    function automatic logic [5:0] pack_out();
        return {mode_two_phase, pd_weak_en, pd_strong_en, soft_on_en, pu_strong_en, seq_done};
    endfunction

    // expected {mode, weak, strong_pd, soft, pu, done} after a latched decision
    function automatic logic [5:0] exp_after_detect(input logic pin_level);
        return pin_level ? 6'b000001 : 6'b101000;
    endfunction

    task automatic chk(input int act, input int exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // R11 monitor
    always @(negedge clk) if (rst_n && !finished)
        if ($countones({pd_weak_en, pd_strong_en, soft_on_en, pu_strong_en}) > 1) begin
            total++; bad++;
            $display("FAIL R11 act=%b exp=onehot0",
                     {pd_weak_en, pd_strong_en, soft_on_en, pu_strong_en});
        end

    // Called at a negedge with supplies and enable just made valid
    task automatic run_detect(input logic lvl, input string tag);
        int dly_cnt = 0;
        int win_cnt = 0;
        @(negedge clk);
        while (!pd_weak_en && dly_cnt < 4*DLY) begin
            dly_cnt++;
            @(negedge clk);
        end
        chk(dly_cnt, DLY, {"R2 ", tag});
        while (pd_weak_en && win_cnt < 4*WIN) begin
            win_cnt++;
            pin_hi_det = (win_cnt == WIN) ? lvl : 1'($urandom % 2);
            @(negedge clk);
        end
        chk(win_cnt, WIN, {"R3 ", tag});
        chk(pack_out(), exp_after_detect(lvl), lvl ? {"R4 ", tag} : {"R5 ", tag});
    endtask

    task automatic clear_inputs();
        en_a = 0; en_b = 0; pin_hi_det = 0; pin_top_det = 0; pg_a = 0; pg_b = 0;
    endtask

    initial begin
        seed_v = $urandom(32'h5eed_0042);
        repeat (3) @(negedge clk);
        chk(pack_out(), 0, "R1 reset");
        rst_n = 1'b1;

        // R1: one supply missing, enable high -> nothing happens
        vin_ok = 1; en_a = 1;
        repeat (3*DLY + WIN) begin
            @(negedge clk);
            if (pack_out() != 0) chk(pack_out(), 0, "R1 one supply");
        end
        chk(pack_out(), 0, "R1 one supply end");
        // R1: supplies ok, no enable
        en_a = 0; vcc_ok = 1;
        repeat (3*DLY) @(negedge clk);
        chk(pack_out(), 0, "R1 no enable");

        // Directed two-phase run
        en_b = 1;
        run_detect(1'b0, "directed tp");
        // R9: toggles after latching
        for (int i = 0; i < 30; i++) begin
            en_a = 1'($urandom % 2); en_b = 1'($urandom % 2);
            pin_hi_det = 1'($urandom % 2);
            @(negedge clk);
            if (pd_weak_en || !mode_two_phase) chk({mode_two_phase, pd_weak_en}, 2'b10, "R9 tp");
        end
        chk({mode_two_phase, pd_weak_en}, 2'b10, "R9 tp end");
        // R6: only one power-good
        pg_a = 1;
        repeat (5) @(negedge clk);
        chk({soft_on_en, pd_strong_en}, 2'b01, "R6 one pg");
        pg_b = 1;
        @(negedge clk);
        chk({soft_on_en, pd_strong_en}, 2'b10, "R6 both pg");
        repeat (4) @(negedge clk);
        chk(soft_on_en, 1, "R6 holds");
        // R8: drop during soft-on
        pg_b = 0;
        @(negedge clk);
        chk({pd_strong_en, soft_on_en, seq_done}, 3'b100, "R8 soft drop");
        pg_b = 1;
        @(negedge clk);
        chk(soft_on_en, 1, "R6 resume");
        pin_top_det = 1;
        @(negedge clk);
        chk({pu_strong_en, seq_done, soft_on_en}, 3'b110, "R7 pull-up");
        pg_a = 0;
        @(negedge clk);
        chk({pd_strong_en, pu_strong_en, seq_done}, 3'b100, "R8 on drop");

        // R10: supply drop and re-detect
        vcc_ok = 0;
        @(negedge clk);
        chk(pack_out(), 0, "R10 supply drop");
        clear_inputs(); en_a = 1; vcc_ok = 1;
        run_detect(1'b1, "directed dual");
        for (int i = 0; i < 20; i++) begin
            en_a = 1'($urandom % 2); pin_hi_det = 1'($urandom % 2);
            @(negedge clk);
            if (pack_out() != 6'b000001) chk(pack_out(), 6'b000001, "R9 dual");
        end
        chk(pack_out(), 6'b000001, "R9 dual end");

        // Random trials
        for (int t = 0; t < 8; t++) begin
            logic lvl;
            lvl = 1'($urandom % 2);
            if ($urandom % 2) vin_ok = 0; else vcc_ok = 0;
            @(negedge clk);
            chk(pack_out(), 0, "R10 random drop");
            clear_inputs(); vin_ok = 1; vcc_ok = 1;
            if ($urandom % 2) en_a = 1; else en_b = 1;
            run_detect(lvl, "random");
            if (!lvl) begin
                pg_a = 1; pg_b = 1;
                @(negedge clk);
                chk(soft_on_en, 1, "R6 random");
                pin_top_det = 1;
                @(negedge clk);
                chk({pu_strong_en, seq_done}, 2'b11, "R7 random");
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule